// File: doc/BRIEF.md
# Pipelined Summed-Area Table Engine

This block builds the integral image (summed-area table) of a grayscale frame of 8-bit unsigned pixels. Both the pixel store and the table store sit outside the engine as synchronous-read memories. After a one-cycle start pulse, the engine visits every position once, in raster order. For each position it reads the pixel and three earlier table entries: the one directly above, the one to the left and the one diagonally above-left. It then writes back pixel + above + left - diagonal, with missing neighbours at the frame edges taken as zero.

The engine has three stages. The first generates addresses. The second is a clocked memory read. The third does the arithmetic and the write-back. All three neighbour addresses go out every cycle, and the final stage decides which returned values to use. Each memory access therefore has its own clock edge, and the table can map to block RAM instead of a wide read multiplexer.

A result written in the last two cycles has not yet reached the memory when a later position reads it. Those results are forwarded from the pipeline registers. When the final position has been written, a completion flag rises and stays high until the next accepted start. Both memories use the linear address r*COLS+c. The default frame is ROWS=79 by COLS=131.

Top module: `integral_image_engine`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy`, `done`, `pix_re` and `sum_we` are all 0.
- R2: After an accepted start, `pix_re` is high for exactly ROWS*COLS consecutive cycles. In that window `pix_addr` starts at 0 and rises by one each cycle, so the position (r,c) is addressed as r*COLS+c with the column changing fastest.
- R3: The value written for position (r,c) equals p(r,c) + I(r-1,c) + I(r,c-1) - I(r-1,c-1). A term from above is 0 on row 0, a term from the left is 0 in column 0, and the diagonal term is used only when r>0 and c>0.
- R4: Each position is written exactly once, in ascending address order. `sum_we` is high with `sum_waddr` equal to that address exactly two cycles after the cycle in which the position's `pix_addr` was presented with `pix_re`.
- R5: The neighbour addresses are presented in the same cycle as `pix_addr`. `sum_up_addr` is addr-COLS when r>0, `sum_left_addr` is addr-1 when c>0, and `sum_diag_addr` is addr-COLS-1 when both hold. A neighbour that does not exist is given address 0. The memory returns each value on the following cycle, and no address reaches ROWS*COLS.
- R6: When a neighbour was written in either of the two cycles before its value is used, the engine takes the pending result rather than the memory data. The memory returns the old contents on a read that coincides with a write to the same address.
- R7: `done` goes high in the cycle after the write of address ROWS*COLS-1. It stays high until a start is accepted, and it reads 0 in the cycle after that start.
- R8: A start pulse while `busy` is high is ignored, and the scan in progress continues without restarting.
- R9: `busy` is high from the cycle after an accepted start through the cycle of the last write, and `sum_we` is never high while `busy` is low.
- R10: With the default SUM_W of 22 bits, a frame of all 255 gives exactly ROWS*COLS*255 at the last address, with no wrap-around.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle pulse that begins a scan when idle |
| pix_re | output | 1 | Read enable for pixel and table reads |
| pix_addr | output | AW | Linear pixel address of the current position |
| pix_data | input | PIX_W | Pixel value, one cycle after `pix_addr` |
| sum_up_addr | output | AW | Table address of the neighbour above |
| sum_left_addr | output | AW | Table address of the neighbour to the left |
| sum_diag_addr | output | AW | Table address of the neighbour above-left |
| sum_up_data | input | SUM_W | Table value above, one cycle after its address |
| sum_left_data | input | SUM_W | Table value to the left, one cycle after its address |
| sum_diag_data | input | SUM_W | Table value above-left, one cycle after its address |
| sum_we | output | 1 | Table write enable |
| sum_waddr | output | AW | Table write address |
| sum_wdata | output | SUM_W | Table write data |
| busy | output | 1 | Scan or pipeline drain in progress |
| done | output | 1 | Last position has been written |

## Verification
The hardest case to bring about is a neighbour read that returns stale memory contents. Forwarding hides this whenever it works, so a memory that starts at zero would let a broken forwarding path go unseen. The bench therefore fills the table memory with random garbage before the first scan and runs further scans over the previous results. Its memory model returns old data when a read and a write hit the same address, so any left neighbour taken from the memory instead of the pipeline gives a wrong sum. A start pulse is also placed in the middle of a scan, and an all-255 frame drives the largest possible sum.

// File: rtl/iie_pkg.sv
`timescale 1ns/1ps
package iie_pkg;

    // neighbour slots; all three are fetched every cycle
    localparam int NB_UP    = 0;
    localparam int NB_LEFT  = 1;
    localparam int NB_DIAG  = 2;
    localparam int NB_COUNT = 3;

    // distance, in linear addresses, from a position back to a neighbour
    function automatic int nb_back(input int slot, input int cols);
        case (slot)
            NB_UP:   return cols;
            NB_LEFT: return 1;
            default: return cols + 1;
        endcase
    endfunction

endpackage

// File: rtl/iie_scan.sv
`timescale 1ns/1ps
module iie_scan #(
    parameter int ROWS = 79,
    parameter int COLS = 131,
    localparam int CELLS = ROWS * COLS,
    localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1,
    localparam int RW = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW = (COLS > 1) ? $clog2(COLS) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    output logic          active,
    output logic [AW-1:0] lin_addr,
    output logic          row_first,
    output logic          col_first,
    output logic          last_pos
);

    typedef struct packed {
        logic          active;
        logic [AW-1:0] lin;
        logic [RW-1:0] row;
        logic [CW-1:0] col;
    } scan_t;

    scan_t scan_d, scan_q;
    logic  col_end, row_end;

    assign col_end = (scan_q.col == CW'(COLS - 1));
    assign row_end = (scan_q.row == RW'(ROWS - 1));

    always_comb begin
        scan_d = scan_q;
        if (launch) begin
            scan_d.active = 1'b1;
            scan_d.lin    = '0;
            scan_d.row    = '0;
            scan_d.col    = '0;
        end else if (scan_q.active) begin
            if (col_end && row_end) begin
                scan_d.active = 1'b0;
            end else begin
                scan_d.lin = scan_q.lin + AW'(1);
                if (col_end) begin
                    scan_d.col = '0;
                    scan_d.row = scan_q.row + RW'(1);
                end else begin
                    scan_d.col = scan_q.col + CW'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) scan_q <= '0;
        else        scan_q <= scan_d;
    end

    assign active    = scan_q.active;
    assign lin_addr  = scan_q.lin;
    assign row_first = (scan_q.row == '0);
    assign col_first = (scan_q.col == '0);
    assign last_pos  = col_end && row_end;

endmodule

// File: rtl/iie_fwd.sv
`timescale 1ns/1ps
module iie_fwd #(
    parameter int AW    = 14,
    parameter int SUM_W = 22
) (
    input  logic [AW-1:0]    want,
    input  logic [SUM_W-1:0] ram_value,
    input  logic             new_valid,
    input  logic [AW-1:0]    new_addr,
    input  logic [SUM_W-1:0] new_value,
    input  logic             old_valid,
    input  logic [AW-1:0]    old_addr,
    input  logic [SUM_W-1:0] old_value,
    output logic [SUM_W-1:0] value
);

    // newest pending write wins over the one that landed at the read edge
    always_comb begin
        value = ram_value;
        if (old_valid && (old_addr == want)) value = old_value;
        if (new_valid && (new_addr == want)) value = new_value;
    end

endmodule

// File: rtl/integral_image_engine.sv
`timescale 1ns/1ps
module integral_image_engine
    import iie_pkg::*;
#(
    parameter int ROWS  = 79,
    parameter int COLS  = 131,
    parameter int PIX_W = 8,
    parameter int SUM_W = 22,
    localparam int CELLS = ROWS * COLS,
    localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             pix_re,
    output logic [AW-1:0]    pix_addr,
    input  logic [PIX_W-1:0] pix_data,
    output logic [AW-1:0]    sum_up_addr,
    output logic [AW-1:0]    sum_left_addr,
    output logic [AW-1:0]    sum_diag_addr,
    input  logic [SUM_W-1:0] sum_up_data,
    input  logic [SUM_W-1:0] sum_left_data,
    input  logic [SUM_W-1:0] sum_diag_data,
    output logic             sum_we,
    output logic [AW-1:0]    sum_waddr,
    output logic [SUM_W-1:0] sum_wdata,
    output logic             busy,
    output logic             done
);

    // stage 2: read returned, metadata aligned with memory data
    typedef struct packed {
        logic                            valid;
        logic                            last;
        logic [AW-1:0]                   addr;
        logic [NB_COUNT-1:0]             use_nb;
        logic [NB_COUNT-1:0][AW-1:0]     nb_addr;
    } rd_stage_t;

    // stage 3: result waiting for its memory write
    typedef struct packed {
        logic             valid;
        logic             last;
        logic [AW-1:0]    addr;
        logic [SUM_W-1:0] sum;
    } wb_stage_t;

    // result written on the previous edge, possibly missed by the read
    typedef struct packed {
        logic             valid;
        logic [AW-1:0]    addr;
        logic [SUM_W-1:0] sum;
    } landed_t;

    typedef struct packed {
        rd_stage_t rd;
        wb_stage_t wb;
        landed_t   landed;
        logic      done;
    } core_t;

    core_t core_d, core_q;

    logic                          launch;
    logic                          row_first, col_first, last_pos;
    logic [NB_COUNT-1:0]           use_now;
    logic [NB_COUNT-1:0][AW-1:0]   nb_now;
    logic [NB_COUNT-1:0][SUM_W-1:0] ram_nb;
    logic [NB_COUNT-1:0][SUM_W-1:0] nb_val;
    logic [SUM_W-1:0]              total;

    assign busy   = pix_re | core_q.rd.valid | core_q.wb.valid;
    assign launch = start & ~busy;

    // stage 1: address generation
    iie_scan #(
        .ROWS(ROWS),
        .COLS(COLS)
    ) u_scan (
        .clk      (clk),
        .rst_n    (rst_n),
        .launch   (launch),
        .active   (pix_re),
        .lin_addr (pix_addr),
        .row_first(row_first),
        .col_first(col_first),
        .last_pos (last_pos)
    );

    always_comb begin
        use_now[NB_UP]   = ~row_first;
        use_now[NB_LEFT] = ~col_first;
        use_now[NB_DIAG] = ~row_first & ~col_first;
    end

    assign ram_nb[NB_UP]   = sum_up_data;
    assign ram_nb[NB_LEFT] = sum_left_data;
    assign ram_nb[NB_DIAG] = sum_diag_data;

    for (genvar g = 0; g < NB_COUNT; g++) begin : g_nb
        assign nb_now[g] = use_now[g] ? (pix_addr - AW'(nb_back(g, COLS))) : '0;

        iie_fwd #(
            .AW   (AW),
            .SUM_W(SUM_W)
        ) u_fwd (
            .want     (core_q.rd.nb_addr[g]),
            .ram_value(ram_nb[g]),
            .new_valid(core_q.wb.valid),
            .new_addr (core_q.wb.addr),
            .new_value(core_q.wb.sum),
            .old_valid(core_q.landed.valid),
            .old_addr (core_q.landed.addr),
            .old_value(core_q.landed.sum),
            .value    (nb_val[g])
        );
    end

    assign sum_up_addr   = nb_now[NB_UP];
    assign sum_left_addr = nb_now[NB_LEFT];
    assign sum_diag_addr = nb_now[NB_DIAG];

    // stage 2 arithmetic: pick neighbours by edge flags
    always_comb begin
        total = SUM_W'(pix_data);
        if (core_q.rd.use_nb[NB_UP])   total = total + nb_val[NB_UP];
        if (core_q.rd.use_nb[NB_LEFT]) total = total + nb_val[NB_LEFT];
        if (core_q.rd.use_nb[NB_DIAG]) total = total - nb_val[NB_DIAG];
    end

    always_comb begin
        core_d = core_q;

        core_d.rd.valid   = pix_re;
        core_d.rd.last    = last_pos;
        core_d.rd.addr    = pix_addr;
        core_d.rd.use_nb  = use_now;
        core_d.rd.nb_addr = nb_now;

        core_d.wb.valid = core_q.rd.valid;
        core_d.wb.last  = core_q.rd.last;
        core_d.wb.addr  = core_q.rd.addr;
        core_d.wb.sum   = total;

        core_d.landed.valid = core_q.wb.valid;
        core_d.landed.addr  = core_q.wb.addr;
        core_d.landed.sum   = core_q.wb.sum;

        if (launch)
            core_d.done = 1'b0;
        else if (core_q.wb.valid && core_q.wb.last)
            core_d.done = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) core_q <= '0;
        else        core_q <= core_d;
    end

    assign sum_we    = core_q.wb.valid;
    assign sum_waddr = core_q.wb.addr;
    assign sum_wdata = core_q.wb.sum;
    assign done      = core_q.done;

endmodule

// File: rtl/iie_checker.sv
`timescale 1ns/1ps
module iie_checker #(
    parameter int ROWS  = 79,
    parameter int COLS  = 131,
    localparam int CELLS = ROWS * COLS,
    localparam int AW = (CELLS > 1) ? $clog2(CELLS) : 1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          pix_re,
    input logic [AW-1:0] pix_addr,
    input logic          sum_we,
    input logic [AW-1:0] sum_waddr,
    input logic          busy,
    input logic          done
);

    localparam logic [AW-1:0] LAST_ADDR = AW'(CELLS - 1);

    p_first_addr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pix_re) |-> pix_addr == '0);

    p_raster_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        pix_re && $past(pix_re) |-> pix_addr == $past(pix_addr) + AW'(1));

    p_addr_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pix_re |-> pix_addr <= LAST_ADDR);

    p_write_lag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pix_re, 2) |-> sum_we && sum_waddr == $past(pix_addr, 2));

    p_done_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done && !start |=> done);

    p_done_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(sum_we) && $past(sum_waddr) == LAST_ADDR);

    p_we_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sum_we |-> busy);

    p_no_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy) && $past(start) && pix_re |-> pix_addr != '0);

endmodule

bind integral_image_engine iie_checker #(
    .ROWS(ROWS),
    .COLS(COLS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .pix_re   (pix_re),
    .pix_addr (pix_addr),
    .sum_we   (sum_we),
    .sum_waddr(sum_waddr),
    .busy     (busy),
    .done     (done)
);

// File: tb/test_integral_image_engine.sv
`timescale 1ns/1ps
module test_integral_image_engine;

    localparam int ROWS  = 23;
    localparam int COLS  = 41;
    localparam int SUM_W = 22;
    localparam int N     = ROWS * COLS;
    localparam int AW    = (N > 1) ? $clog2(N) : 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             pix_re;
    logic [AW-1:0]    pix_addr, up_a, left_a, diag_a, sum_waddr;
    logic [7:0]       pix_data;
    logic [SUM_W-1:0] up_d, left_d, diag_d, sum_wdata;
    logic             sum_we, busy, done;

    always #2.5 clk = ~clk;

    integral_image_engine #(
        .ROWS(ROWS), .COLS(COLS), .PIX_W(8), .SUM_W(SUM_W)
    ) i_integral_image_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .pix_re(pix_re), .pix_addr(pix_addr), .pix_data(pix_data),
        .sum_up_addr(up_a), .sum_left_addr(left_a), .sum_diag_addr(diag_a),
        .sum_up_data(up_d), .sum_left_data(left_d), .sum_diag_data(diag_d),
        .sum_we(sum_we), .sum_waddr(sum_waddr), .sum_wdata(sum_wdata),
        .busy(busy), .done(done)
    );

    // memory models: synchronous read, old data on a same-edge write
    logic [7:0]       pix_mem [N];
    logic [SUM_W-1:0] tab_mem [N];
    int               ref_sum [N];

    always @(posedge clk) begin
        if (pix_re) begin
            pix_data <= pix_mem[pix_addr];
            up_d     <= tab_mem[up_a];
            left_d   <= tab_mem[left_a];
            diag_d   <= tab_mem[diag_a];
        end
        if (sum_we) tab_mem[sum_waddr] <= sum_wdata;
    end

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // cycle-level reference: read stamps queued, writes matched against them
    typedef struct { int a; int t; } rd_rec_t;
    rd_rec_t rdq[$];
    int  exp_rd = 0;
    int  exp_wr = 0;
    bit  mon_on = 1'b0;
    bit  prev_last_we = 1'b0;

    always @(negedge clk) begin
        if (mon_on) begin
            if (pix_re) begin
                int r, c;
                r = exp_rd / COLS;
                c = exp_rd % COLS;
                check(int'(pix_addr) == exp_rd, "R2 R8", "pixel address", pix_addr, exp_rd);
                check(int'(up_a) == ((r > 0) ? exp_rd - COLS : 0), "R5", "up address",
                      up_a, (r > 0) ? exp_rd - COLS : 0);
                check(int'(left_a) == ((c > 0) ? exp_rd - 1 : 0), "R5", "left address",
                      left_a, (c > 0) ? exp_rd - 1 : 0);
                check(int'(diag_a) == ((r > 0 && c > 0) ? exp_rd - COLS - 1 : 0), "R5",
                      "diag address", diag_a, (r > 0 && c > 0) ? exp_rd - COLS - 1 : 0);
                rdq.push_back('{a: exp_rd, t: cyc});
                exp_rd++;
            end
            if (sum_we) begin
                if (rdq.size() == 0) begin
                    check(1'b0, "R4", "write with no pending read", sum_waddr, -1);
                end else begin
                    rd_rec_t rec;
                    rec = rdq.pop_front();
                    check(int'(sum_waddr) == rec.a, "R4", "write address", sum_waddr, rec.a);
                    check(cyc == rec.t + 2, "R4", "write lag cycle", cyc, rec.t + 2);
                    if (int'(sum_waddr) < N)
                        check(int'(sum_wdata) == ref_sum[sum_waddr], "R3 R6", "written sum",
                              sum_wdata, ref_sum[sum_waddr]);
                end
                check(busy == 1'b1, "R9", "busy during write", busy, 1);
                exp_wr++;
            end
            if (prev_last_we)
                check(done == 1'b1, "R7", "done after last write", done, 1);
            if (exp_rd > 0 && exp_wr < N) begin
                check(busy == 1'b1, "R9", "busy mid scan", busy, 1);
                check(done == 1'b0, "R7", "done low mid scan", done, 0);
            end
            prev_last_we = sum_we && (int'(sum_waddr) == N - 1);
        end
    end

    task automatic run_frame(input int mode, input bit poke);
        for (int a = 0; a < N; a++) begin
            case (mode)
                0: pix_mem[a] = 8'($urandom_range(0, 255));
                1: pix_mem[a] = 8'hFF;
                default: pix_mem[a] = 8'((a / COLS) * 7 + (a % COLS) * 3);
            endcase
        end
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                int v;
                v = int'(pix_mem[r * COLS + c]);
                if (r > 0) v += ref_sum[(r - 1) * COLS + c];
                if (c > 0) v += ref_sum[r * COLS + c - 1];
                if (r > 0 && c > 0) v -= ref_sum[(r - 1) * COLS + c - 1];
                ref_sum[r * COLS + c] = v;
            end
        end
        exp_rd = 0;
        exp_wr = 0;
        rdq.delete();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check(done == 1'b0, "R7", "done cleared by start", done, 0);
        check(busy == 1'b1, "R9", "busy after start", busy, 1);
        for (int i = 0; i < N + 20 && !done; i++) begin
            @(negedge clk);
            start = (poke && (i == N / 2 || i == 3)) ? 1'b1 : 1'b0;
        end
        @(negedge clk) start = 1'b0;
        check(exp_wr == N, "R4", "writes per scan", exp_wr, N);
        if (poke) check(exp_rd == N, "R8", "reads per scan despite start", exp_rd, N);
        repeat (4) @(negedge clk);
        check(exp_wr == N, "R4", "no extra writes", exp_wr, N);
        check(done == 1'b1, "R7", "done held", done, 1);
        check(busy == 1'b0, "R9", "idle after scan", busy, 0);
        begin
            int bad = 0;
            for (int a = 0; a < N; a++)
                if (int'(tab_mem[a]) != ref_sum[a]) bad++;
            check(bad == 0, "R3", "table mismatches", bad, 0);
        end
        if (mode == 1)
            check(int'(tab_mem[N - 1]) == N * 255, "R10", "max sum at last address",
                  tab_mem[N - 1], N * 255);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        check(1'b0, "R1", "watchdog expired", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < N; a++) tab_mem[a] = SUM_W'($urandom);
        repeat (4) @(negedge clk);
        check(busy == 1'b0, "R1", "busy in reset", busy, 0);
        check(done == 1'b0, "R1", "done in reset", done, 0);
        check(pix_re == 1'b0, "R1", "pix_re in reset", pix_re, 0);
        check(sum_we == 1'b0, "R1", "sum_we in reset", sum_we, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(busy == 1'b0 && done == 1'b0, "R1", "idle after reset", {busy, done}, 0);
        mon_on = 1'b1;
        run_frame(0, 1'b0);
        run_frame(2, 1'b1);
        run_frame(1, 1'b0);
        run_frame(0, 1'b0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule